// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

A memory-mapped general-purpose I/O block whose pins are grouped in banks of 32, each bank reached through its own 0x200-byte register window. Every pin has an output value, an output enable, a bias setting (off, pull-up or pull-down) and a 3-bit drive-strength code. Every pin also has an interrupt detector that can watch for a level, a single edge, or both edges. The pin count is a parameter. The bank count follows from it.

Software reaches the block through a 32-bit register port. Writes take effect on the clock edge where `regWe` is high. Reads are combinational from `regAddr`. Pad inputs are resynchronised before any detection. Each pin has an interrupt-enable bit, a raw status bit and a masked status bit. A bit is acknowledged by writing a one to the clear register. All masked status bits across every bank are ORed into one interrupt line.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset every register is zero. All pins are inputs (`pinOe`=0), `pinOut`, both pull outputs and `drvCode` are zero, and `irq` is 0.
- R2: Address bits [8:0] select the register and the bits above them select the bank. Pin n lives in bank n/32 at bit n%32. A read returns zero in three cases: an offset outside the decoded set, a bank at or above the bank count, or a bit of a pin that does not exist. The clear register also reads as zero.
- R3: Offset 0x04 holds the output value and offset 0x08 the output enable. `pinOut[n]` and `pinOe[n]` follow their bits, and both registers read back as written.
- R4: Offset 0x00 returns each pin's level after a two-flop synchronizer, two clock edges after the pad changes. Writes to it have no effect.
- R5: Offset 0x38 enables bias and offset 0x34 selects its direction, where 1 means up. `pullUpEn[n]` = enable AND select, and `pullDnEn[n]` = enable AND NOT select.
- R6: The drive-strength code for pin n is `drvCode[3n+2:3n]`. Bit 0 of the code comes from offset 0x58, bit 1 from 0x5C and bit 2 from 0x60. The code stands for (code+1)*2 mA.
- R7: With the type bit (0x0C) at 0 and the dual bit (0x10) at 0, a pin sets its raw status (0x1C) on a rising edge when the polarity bit (0x14) is 1, and on a falling edge when it is 0. Raw status is set on the third clock edge after the pad changes.
- R8: With the type bit at 0 and the dual bit at 1, both edges set raw status and polarity is ignored.
- R9: With the type bit at 1, raw status is set on every cycle the synchronized level equals the polarity bit. If a clear and a set fall in the same cycle, the set wins.
- R10: Writing 1 to a bit of offset 0x24 clears that raw status bit. Writing 0 leaves it unchanged. Writes to 0x1C and 0x20 are ignored.
- R11: Masked status (0x20) is raw status AND the interrupt enable (0x18). `irq` is high exactly when any masked bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address: bank above bit 9, offset below |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| pinIn | input | PIN_COUNT | Pad input levels |
| pinOut | output | PIN_COUNT | Pad output values |
| pinOe | output | PIN_COUNT | Pad output enables |
| pullUpEn | output | PIN_COUNT | Pull-up enable per pin |
| pullDnEn | output | PIN_COUNT | Pull-down enable per pin |
| drvCode | output | 3*PIN_COUNT | 3-bit drive code per pin |
| irq | output | 1 | OR of all masked status bits |

## Verification
The bench uses a partial second bank, so pins that do not exist must read as zero. A design that let those bits through would return 0xFFFFFFFF instead of 0xFF after all-ones writes. A clear issued while a level-sensitive pin is still active must leave the status set. An inverted set/clear priority would drop that event. Writing zero to the clear register, or writing to the status registers, must leave raw status untouched. A decoder that treated clear as a plain store, or made status writable, would lose a pending interrupt. The bench also compares `irq` against the reference model on every cycle. This catches wrong edge polarity and a dual-edge setting that fails to override polarity, through the exact cycle at which the line rises.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int BANK_PINS = 32;
  localparam int WIN_BITS  = 9;

  typedef enum logic [3:0] {
    R_DIN, R_DOUT, R_OE, R_TYPE, R_DUAL, R_POL, R_MASK,
    R_RAW, R_MSTAT, R_CLR, R_PSEL, R_PEN, R_DRV0, R_DRV1, R_DRV2
  } regId_e;

  typedef struct packed {
    logic   wr;
    logic   hit;
    regId_e id;
  } strobe_t;
endpackage

// File: rtl/bpc_event.sv
module bpc_event #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] padIn,
  input  logic [W-1:0] typeLvl,
  input  logic [W-1:0] dualEdge,
  input  logic [W-1:0] polHigh,
  output logic [W-1:0] hit,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] meta, cur, prev;
  logic [W-1:0] rise, fall, lvlHit, edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= padIn;
      cur  <= meta;
      prev <= cur;
    end
  end

  always_comb begin
    rise    = cur & ~prev;
    fall    = ~cur & prev;
    lvlHit  = ~(cur ^ polHigh);
    edgeHit = (dualEdge & (rise | fall)) |
              (~dualEdge & ((polHigh & rise) | (~polHigh & fall)));
    hit     = (typeLvl & lvlHit) | (~typeLvl & edgeHit);
  end

  assign syncOut = cur;
endmodule

// File: rtl/bpc_ctrl.sv
module bpc_ctrl import bpc_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe,
  output logic [BANK_W-1:0] bankSel
);
  localparam int UP_W = ADDR_W - WIN_BITS;

  logic [UP_W-1:0] upper;
  logic            bankOk;
  logic            offHit;
  regId_e          id;

  assign upper   = regAddr[ADDR_W-1:WIN_BITS];
  assign bankOk  = upper < UP_W'(NUM_BANKS);
  assign bankSel = upper[BANK_W-1:0];

  always_comb begin
    offHit = 1'b1;
    id     = R_DIN;
    case (regAddr[WIN_BITS-1:0])
      9'h000:  id = R_DIN;
      9'h004:  id = R_DOUT;
      9'h008:  id = R_OE;
      9'h00C:  id = R_TYPE;
      9'h010:  id = R_DUAL;
      9'h014:  id = R_POL;
      9'h018:  id = R_MASK;
      9'h01C:  id = R_RAW;
      9'h020:  id = R_MSTAT;
      9'h024:  id = R_CLR;
      9'h034:  id = R_PSEL;
      9'h038:  id = R_PEN;
      9'h058:  id = R_DRV0;
      9'h05C:  id = R_DRV1;
      9'h060:  id = R_DRV2;
      default: offHit = 1'b0;
    endcase
  end

  always_comb begin
    strobe.hit = offHit & bankOk;
    strobe.wr  = regWe & offHit & bankOk;
    strobe.id  = id;
  end
endmodule

// File: rtl/bpc_datapath.sv
module bpc_datapath import bpc_pkg::*; #(
  parameter int PIN_COUNT = 40,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [BANK_W-1:0]      bankSel,
  input  logic [31:0]            wdata,
  input  logic [PIN_COUNT-1:0]   pinIn,
  output logic [31:0]            rdata,
  output logic [PIN_COUNT-1:0]   pinOut,
  output logic [PIN_COUNT-1:0]   pinOe,
  output logic [PIN_COUNT-1:0]   pullUpEn,
  output logic [PIN_COUNT-1:0]   pullDnEn,
  output logic [3*PIN_COUNT-1:0] drvCode,
  output logic                   irq
);
  localparam int TOT = NUM_BANKS * BANK_PINS;

  function automatic logic [TOT-1:0] validBits();
    logic [TOT-1:0] v;
    for (int i = 0; i < TOT; i++) v[i] = (i < PIN_COUNT);
    return v;
  endfunction
  localparam logic [TOT-1:0] VALID = validBits();

  logic [TOT-1:0] padIn;
  logic [TOT-1:0] maskQ, rawQ, rdFlat;

  assign padIn = TOT'(pinIn);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam logic [31:0] VM = VALID[b*BANK_PINS +: BANK_PINS];
    localparam int CNT = (PIN_COUNT - b*BANK_PINS > BANK_PINS) ? BANK_PINS
                                                              : PIN_COUNT - b*BANK_PINS;
    logic [31:0] dout, oe, typ, dual, pol, msk, raw, psel, pen, d0, d1, d2;
    logic [31:0] hit, syncV, wVal, clrV, rdV;
    logic        wrHere;

    assign wrHere = strobe.wr && (bankSel == BANK_W'(b));
    assign wVal   = wdata & VM;
    assign clrV   = (wrHere && strobe.id == R_CLR) ? wdata : '0;

    bpc_event #(.W(BANK_PINS)) uEv (
      .clk(clk), .rstN(rstN), .padIn(padIn[b*BANK_PINS +: BANK_PINS]),
      .typeLvl(typ), .dualEdge(dual), .polHigh(pol),
      .hit(hit), .syncOut(syncV)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dout <= '0; oe <= '0; typ <= '0; dual <= '0; pol <= '0; msk <= '0;
        raw <= '0; psel <= '0; pen <= '0; d0 <= '0; d1 <= '0; d2 <= '0;
      end else begin
        raw <= (raw & ~clrV) | (hit & VM);
        if (wrHere) begin
          case (strobe.id)
            R_DOUT:  dout <= wVal;
            R_OE:    oe   <= wVal;
            R_TYPE:  typ  <= wVal;
            R_DUAL:  dual <= wVal;
            R_POL:   pol  <= wVal;
            R_MASK:  msk  <= wVal;
            R_PSEL:  psel <= wVal;
            R_PEN:   pen  <= wVal;
            R_DRV0:  d0   <= wVal;
            R_DRV1:  d1   <= wVal;
            R_DRV2:  d2   <= wVal;
            default: ;
          endcase
        end
      end
    end

    always_comb begin
      case (strobe.id)
        R_DIN:   rdV = syncV & VM;
        R_DOUT:  rdV = dout;
        R_OE:    rdV = oe;
        R_TYPE:  rdV = typ;
        R_DUAL:  rdV = dual;
        R_POL:   rdV = pol;
        R_MASK:  rdV = msk;
        R_RAW:   rdV = raw;
        R_MSTAT: rdV = raw & msk;
        R_PSEL:  rdV = psel;
        R_PEN:   rdV = pen;
        R_DRV0:  rdV = d0;
        R_DRV1:  rdV = d1;
        R_DRV2:  rdV = d2;
        default: rdV = '0;
      endcase
    end

    assign rdFlat[b*BANK_PINS +: BANK_PINS] = rdV;
    assign maskQ[b*BANK_PINS +: BANK_PINS]  = msk;
    assign rawQ[b*BANK_PINS +: BANK_PINS]   = raw;

    assign pinOut[b*BANK_PINS +: CNT]   = dout[CNT-1:0];
    assign pinOe[b*BANK_PINS +: CNT]    = oe[CNT-1:0];
    assign pullUpEn[b*BANK_PINS +: CNT] = pen[CNT-1:0] & psel[CNT-1:0];
    assign pullDnEn[b*BANK_PINS +: CNT] = pen[CNT-1:0] & ~psel[CNT-1:0];

    for (genvar k = 0; k < CNT; k++) begin : gDrv
      assign drvCode[3*(b*BANK_PINS+k) +: 3] = {d2[k], d1[k], d0[k]};
    end
  end

  assign rdata = strobe.hit ? rdFlat[int'(bankSel)*BANK_PINS +: BANK_PINS] : '0;
  assign irq   = |(rawQ & maskQ);
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl import bpc_pkg::*; #(
  parameter int PIN_COUNT = 40,
  parameter int ADDR_W    = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic [PIN_COUNT-1:0]   pinIn,
  output logic [PIN_COUNT-1:0]   pinOut,
  output logic [PIN_COUNT-1:0]   pinOe,
  output logic [PIN_COUNT-1:0]   pullUpEn,
  output logic [PIN_COUNT-1:0]   pullDnEn,
  output logic [3*PIN_COUNT-1:0] drvCode,
  output logic                   irq
);
  localparam int NUM_BANKS = (PIN_COUNT + BANK_PINS - 1) / BANK_PINS;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  strobe_t           strobe;
  logic [BANK_W-1:0] bankSel;

  bpc_ctrl #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) uCtrl (
    .regWe(regWe), .regAddr(regAddr), .strobe(strobe), .bankSel(bankSel)
  );

  bpc_datapath #(.PIN_COUNT(PIN_COUNT), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankSel(bankSel), .wdata(regWdata),
    .pinIn(pinIn), .rdata(regRdata), .pinOut(pinOut), .pinOe(pinOe),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn), .drvCode(drvCode), .irq(irq)
  );
endmodule

// File: rtl/banked_gpio_ctrl_checker.sv
module banked_gpio_ctrl_checker #(
  parameter int PIN_COUNT = 40,
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWe,
  input logic [ADDR_W-1:0]      regAddr,
  input logic [31:0]            regRdata,
  input logic [PIN_COUNT-1:0]   pinOe,
  input logic [PIN_COUNT-1:0]   pullUpEn,
  input logic [PIN_COUNT-1:0]   pullDnEn,
  input logic [3*PIN_COUNT-1:0] drvCode,
  input logic                   irq,
  input logic [NUM_BANKS*32-1:0] maskQ
);
  logic offLegal, bankLegal;
  always_comb begin
    offLegal = regAddr[8:0] inside {9'h000, 9'h004, 9'h008, 9'h00C, 9'h010,
                                    9'h014, 9'h018, 9'h01C, 9'h020, 9'h034,
                                    9'h038, 9'h058, 9'h05C, 9'h060};
    bankLegal = (int'(regAddr[ADDR_W-1:9]) < NUM_BANKS);
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && drvCode == '0 && !irq));

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(offLegal && bankLegal) |-> regRdata == '0);

  a_r3_oe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(pinOe));

  a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (pullUpEn & pullDnEn) == '0);

  a_r5_pull_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ($stable(pullUpEn) && $stable(pullDnEn)));

  a_r6_drv_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(drvCode));

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);
endmodule

bind banked_gpio_ctrl banked_gpio_ctrl_checker #(
  .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)
) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regRdata(regRdata),
  .pinOe(pinOe), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn), .drvCode(drvCode),
  .irq(irq), .maskQ(uDp.maskQ)
);

// File: tb/banked_gpio_ctrl_test.sv
module banked_gpio_ctrl_test;
  localparam int PINS = 40;
  localparam int NB   = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [15:0]       regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic [PINS-1:0]   pinIn = '0;
  logic [PINS-1:0]   pinOut, pinOe, pullUpEn, pullDnEn;
  logic [3*PINS-1:0] drvCode;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  banked_gpio_ctrl #(.PIN_COUNT(PINS), .ADDR_W(16)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn), .drvCode(drvCode), .irq(irq)
  );

  always #5 clk = ~clk;

  // reference model state, one word per bank
  bit [31:0] mDout[NB], mOe[NB], mTyp[NB], mDual[NB], mPol[NB], mMsk[NB];
  bit [31:0] mRaw[NB], mPsel[NB], mPen[NB], mD0[NB], mD1[NB], mD2[NB];
  bit [PINS-1:0] s1, s2, pv;

  function automatic bit [31:0] validOf(int b);
    bit [31:0] v = '0;
    for (int i = 0; i < 32; i++) v[i] = (b*32 + i < PINS);
    return v;
  endfunction

  function automatic bit [31:0] syncOf(int b);
    bit [31:0] v = '0;
    for (int i = 0; i < 32; i++) if (b*32 + i < PINS) v[i] = s2[b*32+i];
    return v;
  endfunction

  function automatic bit [31:0] mRead(logic [15:0] a);
    int b = int'(a[15:9]);
    if (b >= NB) return '0;
    case (a[8:0])
      9'h000: return syncOf(b);
      9'h004: return mDout[b];
      9'h008: return mOe[b];
      9'h00C: return mTyp[b];
      9'h010: return mDual[b];
      9'h014: return mPol[b];
      9'h018: return mMsk[b];
      9'h01C: return mRaw[b];
      9'h020: return mRaw[b] & mMsk[b];
      9'h034: return mPsel[b];
      9'h038: return mPen[b];
      9'h058: return mD0[b];
      9'h05C: return mD1[b];
      9'h060: return mD2[b];
      default: return '0;
    endcase
  endfunction

  task automatic modelStep();
    if (!rstN) begin
      for (int b = 0; b < NB; b++) begin
        mDout[b] = 0; mOe[b] = 0; mTyp[b] = 0; mDual[b] = 0; mPol[b] = 0; mMsk[b] = 0;
        mRaw[b] = 0; mPsel[b] = 0; mPen[b] = 0; mD0[b] = 0; mD1[b] = 0; mD2[b] = 0;
      end
      s1 = '0; s2 = '0; pv = '0;
      return;
    end
    for (int b = 0; b < NB; b++) begin
      bit [31:0] clr = '0;
      bit [31:0] w = regWdata & validOf(b);
      bit wrB = regWe && int'(regAddr[15:9]) == b;
      if (wrB && regAddr[8:0] == 9'h024) clr = regWdata;
      for (int i = 0; i < 32; i++) begin
        int p = b*32 + i;
        bit h = 0;
        if (p < PINS) begin
          if (mTyp[b][i]) h = mPol[b][i] ? s2[p] : !s2[p];
          else if (mDual[b][i]) h = (s2[p] != pv[p]);
          else if (mPol[b][i]) h = s2[p] && !pv[p];
          else h = !s2[p] && pv[p];
        end
        mRaw[b][i] = (mRaw[b][i] && !clr[i]) || h;
      end
      if (wrB) begin
        case (regAddr[8:0])
          9'h004: mDout[b] = w;
          9'h008: mOe[b]   = w;
          9'h00C: mTyp[b]  = w;
          9'h010: mDual[b] = w;
          9'h014: mPol[b]  = w;
          9'h018: mMsk[b]  = w;
          9'h034: mPsel[b] = w;
          9'h038: mPen[b]  = w;
          9'h058: mD0[b]   = w;
          9'h05C: mD1[b]   = w;
          9'h060: mD2[b]   = w;
          default: ;
        endcase
      end
    end
    pv = s2; s2 = s1; s1 = pinIn;
  endtask

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareOuts();
    bit [PINS-1:0] eOut, eOe, eUp, eDn;
    bit [3*PINS-1:0] eDrv;
    bit eIrq = 0;
    for (int p = 0; p < PINS; p++) begin
      int b = p / 32; int i = p % 32;
      eOut[p] = mDout[b][i]; eOe[p] = mOe[b][i];
      eUp[p] = mPen[b][i] && mPsel[b][i];
      eDn[p] = mPen[b][i] && !mPsel[b][i];
      eDrv[3*p +: 3] = {mD2[b][i], mD1[b][i], mD0[b][i]};
    end
    for (int b = 0; b < NB; b++) if ((mRaw[b] & mMsk[b]) != 0) eIrq = 1;
    check(pinOut === eOut, "R3 pinOut", pinOut, eOut);
    check(pinOe === eOe, "R3 pinOe", pinOe, eOe);
    check(pullUpEn === eUp, "R5 pullUpEn", pullUpEn, eUp);
    check(pullDnEn === eDn, "R5 pullDnEn", pullDnEn, eDn);
    check(drvCode === eDrv, "R6 drvCode", drvCode, eDrv);
    check(irq === eIrq, "R11 irq", irq, eIrq);
  endtask

  always @(posedge clk) begin
    modelStep();
    #2;
    if (rstN && !finished) compareOuts();
  end

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(logic [15:0] a, string tag);
    bit [31:0] e;
    @(negedge clk); regWe = 0; regAddr = a; #1;
    e = mRead(a);
    check(regRdata === e, tag, regRdata, e);
  endtask

  task automatic rdExp(logic [15:0] a, logic [31:0] e, string tag);
    @(negedge clk); regWe = 0; regAddr = a; #1;
    check(regRdata === e, tag, regRdata, e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(int p, bit v);
    @(negedge clk); pinIn[p] = v;
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1 reset values
    rdExp(16'h0008, 0, "R1 oe reset");
    rdExp(16'h0018, 0, "R1 mask reset");
    rdExp(16'h021C, 0, "R1 raw reset");
    check(pinOe === '0 && drvCode === '0 && irq === 0, "R1 outputs", {pinOe, irq}, 0);

    // R3 output data and enable
    wr(16'h0008, 32'h0000_00FF);
    wr(16'h0004, 32'h0000_00A5);
    rdExp(16'h0004, 32'hA5, "R3 dout readback");
    wr(16'h0208, 32'hFFFF_FFFF);
    rdExp(16'h0208, 32'h0000_00FF, "R2 missing pins read zero");
    wr(16'h0204, 32'h0000_0081);
    rd(16'h0204, "R3 bank1 dout");

    // R2 unused offsets and banks
    rdExp(16'h0028, 0, "R2 unused 0x28");
    rdExp(16'h003C, 0, "R2 unused 0x3C");
    rdExp(16'h0024, 0, "R2 clear reads zero");
    wr(16'h0408, 32'hFFFF_FFFF);
    rdExp(16'h0408, 0, "R2 bank out of range");

    // R5 pulls
    wr(16'h0038, 32'h0000_000F);
    wr(16'h0034, 32'h0000_0005);
    rd(16'h0034, "R5 psel readback");
    wr(16'h0238, 32'h0000_0003);

    // R6 drive strength planes
    wr(16'h0058, 32'h0000_0009);
    wr(16'h005C, 32'h0000_0008);
    wr(16'h0060, 32'h0000_000A);
    wr(16'h0260, 32'h0000_0002);
    check(drvCode[3*3 +: 3] === 3'd7, "R6 pin3 code", drvCode[3*3 +: 3], 7);
    check(drvCode[3*33 +: 3] === 3'd4, "R6 pin33 code", drvCode[3*33 +: 3], 4);

    // R4 synchronized input; writes ignored
    setPin(2, 1);
    setPin(35, 1);
    idle(3);
    rdExp(16'h0000, 32'h0000_0004, "R4 input bank0");
    rdExp(16'h0200, 32'h0000_0008, "R4 input bank1");
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, "R4 input write ignored");

    // R7 rising edge on pin 4
    wr(16'h0014, 32'h0000_0010);
    wr(16'h0018, 32'h0000_0010);
    setPin(4, 1);
    idle(4);
    rdExp(16'h001C, 32'h0000_0010, "R7 rising edge");
    rd(16'h0020, "R11 masked status");

    // R10 clear semantics
    wr(16'h0024, 32'h0);
    rdExp(16'h001C, 32'h0000_0010, "R10 zero clear no effect");
    wr(16'h001C, 32'h0);
    wr(16'h0020, 32'h0);
    rdExp(16'h001C, 32'h0000_0010, "R10 status write ignored");
    wr(16'h0024, 32'h0000_0010);
    rdExp(16'h001C, 0, "R10 clear");
    setPin(4, 0);
    idle(4);
    rdExp(16'h001C, 0, "R7 falling ignored when rising");

    // R7 falling edge on pin 5
    setPin(5, 1);
    idle(4);
    rdExp(16'h001C, 0, "R7 rise ignored for falling");
    setPin(5, 0);
    idle(4);
    rdExp(16'h001C, 32'h0000_0020, "R7 falling edge");
    wr(16'h0024, 32'h0000_0020);

    // R8 dual edge on pin 6
    wr(16'h0010, 32'h0000_0040);
    wr(16'h0018, 32'h0000_0040);
    setPin(6, 1);
    idle(4);
    rdExp(16'h001C, 32'h0000_0040, "R8 dual rise");
    wr(16'h0024, 32'h0000_0040);
    setPin(6, 0);
    idle(4);
    rdExp(16'h001C, 32'h0000_0040, "R8 dual fall");
    rd(16'h0020, "R11 masked dual");

    // R11 mask off: status kept, irq low
    wr(16'h0018, 32'h0);
    rdExp(16'h0020, 0, "R11 masked off");
    check(irq === 0, "R11 irq low when masked", irq, 0);
    wr(16'h0024, 32'hFFFF_FFFF);

    // R9 level high on pin 36 (bank1 bit 4)
    wr(16'h0214, 32'h0000_0010);
    wr(16'h0218, 32'h0000_0010);
    wr(16'h020C, 32'h0000_0010);
    rdExp(16'h021C, 0, "R9 level idle");
    setPin(36, 1);
    idle(4);
    rdExp(16'h021C, 32'h0000_0010, "R9 level high");
    check(irq === 1, "R11 irq from bank1", irq, 1);
    wr(16'h0224, 32'h0000_0010);
    rdExp(16'h021C, 32'h0000_0010, "R9 set wins over clear");
    setPin(36, 0);
    idle(4);
    wr(16'h0224, 32'h0000_0010);
    rdExp(16'h021C, 0, "R9 cleared after release");

    // R9 level low on pin 37
    wr(16'h020C, 32'h0000_0030);
    idle(2);
    rdExp(16'h021C, 32'h0000_0020, "R9 level low");
    idle(3);
    finish();
  end
endmodule